// File: doc/BRIEF.md
# Serial Power Switch Matrix Controller

This block drives the power switches of two card slots from a three-wire serial port made of data, clock and latch lines. A host shifts in a 9-bit control word, one bit per rising edge of the serial clock, and then strobes the latch line. On that strobe the word becomes the active setting. The active setting is decoded into twelve switch enables: three for each slot's main supply output (ground, 3.3 V, 5 V) and three for each slot's programming-supply output (ground, follow the main supply, 12 V).

The serial lines are asynchronous to the system clock. They pass through synchronizers, and their rising edges are detected in the system clock domain. Each output group is guarded by break-before-make logic, so that at most one of its switches is closed at a time. A changeover always passes through one cycle with every switch of that output open. A global active-low shutdown bit in the word opens every switch. A thermal fault input also opens every switch, for as long as it is held. The per-output overcurrent flags are merged into one registered active-low fault pin. These flags never change the switch settings.

Top module: `pwr_switch_ctrl`

## Requirements
- R1: The first bit shifted after a latch lands in word bit D8 and the ninth lands in D0. A bit is taken from `ser_data` on each rising edge of `ser_clk`.
- R2: Switch enables change only after a rising edge of `ser_latch`, or when the thermal fault changes. Shifting a new word without a latch strobe leaves `sw_en` unchanged.
- R3: While `rst` is high and after it, until the first latch, `sw_en` is all zero and `fault_n` is high.
- R4: When latched D8 is 0, all twelve bits of `sw_en` are 0, whatever the other eight bits hold.
- R5: Programming outputs use the pair (D0,D1) for slot A and (D4,D5) for slot B, with the first-named bit first. Pair 00 sets the group bit 0 (ground), 01 sets bit 1 (follow main), 10 sets bit 2 (12 V), and 11 sets no bit. Slot A's programming group is `sw_en[5:3]` and slot B's is `sw_en[11:9]`.
- R6: Main outputs use the pair (D3,D2) for slot A and (D6,D7) for slot B, with the first-named bit first. Pair 00 sets group bit 0 (ground), 01 sets bit 1 (3.3 V), 10 sets bit 2 (5 V), and 11 sets bit 0 (ground). Slot A's main group is `sw_en[2:0]` and slot B's is `sw_en[8:6]`.
- R7: No 3-bit group of `sw_en` ever has more than one bit set.
- R8: A group never goes straight from one nonzero value to a different nonzero value. At least one all-zero cycle lies between them.
- R9: `fault_n` is low in the cycle after any bit of `oc_flag` is high, and high in the cycle after all four bits are low. `oc_flag` has no effect on `sw_en`.
- R10: While `therm_fault` is held high, `sw_en` becomes all zero within four cycles. After `therm_fault` clears, the latched setting returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial control data |
| ser_clk | input | 1 | Serial shift clock, rising edge samples data |
| ser_latch | input | 1 | Rising edge transfers the shifted word to the active setting |
| oc_flag | input | 4 | Overcurrent flags: bit0 A main, bit1 A prog, bit2 B main, bit3 B prog |
| therm_fault | input | 1 | Thermal fault, high opens every switch |
| sw_en | output | 12 | Switch enables, four 3-bit groups as defined in R5 and R6 |
| fault_n | output | 1 | Merged overcurrent indicator, active low |

## Verification
A wrong holding register or a wrong shift order appears as a wrong `sw_en` pattern a few cycles after the latch strobe, once the synchronizer and break-before-make stages have passed. A stuck break-before-make state shows as two switches of one group closed together, or as a direct swap between supplies. Either fault is visible in the very cycle it happens. A decode error on a single pair shows only for the words that use that pair, so the bench sweeps all 512 words and checks each one after it settles.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int WORD_W  = 9;
  localparam int GRP_W   = 3;
  localparam int NUM_GRP = 4;
  localparam int SW_W    = GRP_W * NUM_GRP;

  // Word bit positions (decoded by the switch logic)
  localparam int SHDN_N  = 8;
  localparam int A_PGM   = 0;
  localparam int A_SELM  = 1;
  localparam int A_MHI   = 3;
  localparam int A_MLO   = 2;
  localparam int B_PGM   = 4;
  localparam int B_SELM  = 5;
  localparam int B_MHI   = 6;
  localparam int B_MLO   = 7;

  // Main supply: bit0 ground, bit1 3.3 V, bit2 5 V
  function automatic logic [GRP_W-1:0] main_sel(input logic hi, input logic lo);
    case ({hi, lo})
      2'b01:   main_sel = 3'b010;
      2'b10:   main_sel = 3'b100;
      default: main_sel = 3'b001;
    endcase
  endfunction

  // Programming supply: bit0 ground, bit1 follow main, bit2 12 V
  function automatic logic [GRP_W-1:0] prog_sel(input logic pgm, input logic selm);
    case ({pgm, selm})
      2'b00:   prog_sel = 3'b001;
      2'b01:   prog_sel = 3'b010;
      2'b10:   prog_sel = 3'b100;
      default: prog_sel = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/pss_rise.sv
module pss_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pss_shift.sv
module pss_shift #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic         bit_in,
  input  logic         load,
  output logic [W-1:0] word_q
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      word_q <= '0;
    end else begin
      if (sample) shreg  <= {shreg[W-2:0], bit_in};
      if (load)   word_q <= shreg;
    end
  end
endmodule

// File: rtl/pss_decode.sv
module pss_decode
  import pss_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              therm,
  output logic [SW_W-1:0]   tgt
);
  always_comb begin
    tgt = '0;
    if (word[SHDN_N] && !therm) begin
      tgt[0*GRP_W +: GRP_W] = main_sel(word[A_MHI], word[A_MLO]);
      tgt[1*GRP_W +: GRP_W] = prog_sel(word[A_PGM], word[A_SELM]);
      tgt[2*GRP_W +: GRP_W] = main_sel(word[B_MHI], word[B_MLO]);
      tgt[3*GRP_W +: GRP_W] = prog_sel(word[B_PGM], word[B_SELM]);
    end
  end
endmodule

// File: rtl/pss_bbm.sv
module pss_bbm #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tgt,
  output logic [W-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst)                          en <= '0;
    else if (tgt == en)               en <= en;
    else if (en != '0 && tgt != '0)   en <= '0;   // open first
    else                              en <= tgt;
  end
endmodule

// File: rtl/pwr_switch_ctrl.sv
module pwr_switch_ctrl
  import pss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_data,
  input  logic                ser_clk,
  input  logic                ser_latch,
  input  logic [NUM_GRP-1:0]  oc_flag,
  input  logic                therm_fault,
  output logic [SW_W-1:0]     sw_en,
  output logic                fault_n
);
  logic data_s, sclk_s, latch_s, therm_s;
  logic sclk_rise, latch_rise;
  logic [WORD_W-1:0] word_q;
  logic [SW_W-1:0]   tgt;

  pss_sync #(.STAGES(SYNC_STAGES)) u_sync_d (.clk(clk), .rst(rst), .din(ser_data),    .dout(data_s));
  pss_sync #(.STAGES(SYNC_STAGES)) u_sync_c (.clk(clk), .rst(rst), .din(ser_clk),     .dout(sclk_s));
  pss_sync #(.STAGES(SYNC_STAGES)) u_sync_l (.clk(clk), .rst(rst), .din(ser_latch),   .dout(latch_s));
  pss_sync #(.STAGES(SYNC_STAGES)) u_sync_t (.clk(clk), .rst(rst), .din(therm_fault), .dout(therm_s));

  pss_rise u_rise_c (.clk(clk), .rst(rst), .lvl(sclk_s),  .rise(sclk_rise));
  pss_rise u_rise_l (.clk(clk), .rst(rst), .lvl(latch_s), .rise(latch_rise));

  pss_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sample(sclk_rise), .bit_in(data_s),
    .load(latch_rise), .word_q(word_q)
  );

  pss_decode u_dec (.word(word_q), .therm(therm_s), .tgt(tgt));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pss_bbm #(.W(GRP_W)) u_bbm (
      .clk(clk), .rst(rst),
      .tgt(tgt[g*GRP_W +: GRP_W]),
      .en(sw_en[g*GRP_W +: GRP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b1;
    else     fault_n <= ~|oc_flag;
  end
endmodule

// File: rtl/pss_checker.sv
module pss_checker
  import pss_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [NUM_GRP-1:0] oc_flag,
  input logic               therm_fault,
  input logic [SW_W-1:0]    sw_en,
  input logic               fault_n
);
  // R3
  reset_state_chk: assert property (@(posedge clk) rst |=> (sw_en == '0 && fault_n));

  // R9
  oc_low_chk: assert property (@(posedge clk) disable iff (rst) (|oc_flag) |=> !fault_n);

  // R9
  oc_high_chk: assert property (@(posedge clk) disable iff (rst) !(|oc_flag) |=> fault_n);

  // R10
  therm_open_chk: assert property (@(posedge clk) disable iff (rst)
    (therm_fault && $past(therm_fault) && $past(therm_fault, 2)) |=> sw_en == '0);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    // R7
    one_switch_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sw_en[g*GRP_W +: GRP_W]));

    // R8
    break_make_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(sw_en[g*GRP_W +: GRP_W]) != '0 && sw_en[g*GRP_W +: GRP_W] != '0)
        |-> sw_en[g*GRP_W +: GRP_W] == $past(sw_en[g*GRP_W +: GRP_W]));
  end
endmodule

bind pwr_switch_ctrl pss_checker u_pss_checker (
  .clk(clk), .rst(rst), .oc_flag(oc_flag), .therm_fault(therm_fault),
  .sw_en(sw_en), .fault_n(fault_n)
);

// File: tb/test_pwr_switch_ctrl.sv
module test_pwr_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
  logic [3:0]  oc_flag = 4'h0;
  logic        therm_fault = 1'b0;
  logic [11:0] sw_en;
  logic        fault_n;

  int checks = 0;
  int failures = 0;
  logic        mon_on = 1'b0;
  logic [11:0] mon_prev = '0;

  pwr_switch_ctrl i_pwr_switch_ctrl (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .oc_flag(oc_flag), .therm_fault(therm_fault),
    .sw_en(sw_en), .fault_n(fault_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] exp_main(input logic hi, input logic lo);
    logic [1:0] c = {hi, lo};
    return (c == 2'd1) ? 3'b010 : (c == 2'd2) ? 3'b100 : 3'b001;
  endfunction

  function automatic logic [2:0] exp_prog(input logic pgm, input logic sel);
    logic [1:0] c = {pgm, sel};
    return (c == 2'd3) ? 3'b000 : 3'(1 << c);
  endfunction

  function automatic logic [11:0] exp_en(input logic [8:0] w);
    if (!w[8]) return 12'h000;
    return {exp_prog(w[4], w[5]), exp_main(w[6], w[7]),
            exp_prog(w[0], w[1]), exp_main(w[3], w[2])};
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic shift_word(input logic [8:0] w);
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      repeat (HALF_SCLK) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF_SCLK) @(negedge clk);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe_latch();
    repeat (HALF_SCLK) @(negedge clk);
    ser_latch = 1'b1;
    repeat (HALF_SCLK) @(negedge clk);
    ser_latch = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // R7 and R8 watched on every cycle
  always @(negedge clk) begin
    if (mon_on) begin
      for (int g = 0; g < 4; g++) begin
        logic [2:0] cur = sw_en[g*3 +: 3];
        logic [2:0] prv = mon_prev[g*3 +: 3];
        checks++;
        if ($countones(cur) > 1) begin
          failures++;
          $display("FAIL R7: group %0d actual=%03b expected at most one bit", g, cur);
        end
        if (prv != 3'b000 && cur != 3'b000 && cur != prv) begin
          failures++;
          $display("FAIL R8: group %0d actual=%03b expected 000 after %03b", g, cur, prv);
        end
      end
    end
    mon_prev = sw_en;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] cur_exp = '0;
    repeat (4) @(negedge clk);
    chk("R3", sw_en, 12'h000);
    chk("R3", {11'd0, fault_n}, 12'h001);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", sw_en, 12'h000);
    mon_on = 1'b1;

    for (int k = 0; k < 512; k++) begin
      logic [8:0] w = 9'(k);
      if (k % 16 == 5) begin
        shift_word(~w);
        repeat (12) @(negedge clk);
        chk("R2", sw_en, cur_exp);
      end
      shift_word(w);
      strobe_latch();
      cur_exp = exp_en(w);
      chk(w[8] ? "R1 R5 R6" : "R4", sw_en, cur_exp);
      if (k % 32 == 17) begin
        therm_fault = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", sw_en, 12'h000);
        therm_fault = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10", sw_en, cur_exp);
      end
    end

    // R9 over all flag patterns, with a live setting
    shift_word(9'h1A6);
    strobe_latch();
    cur_exp = exp_en(9'h1A6);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk); oc_flag = 4'(p);
      repeat (2) @(negedge clk);
      chk("R9", {11'd0, fault_n}, {11'd0, (p == 0)});
      chk("R9", sw_en, cur_exp);
    end
    oc_flag = 4'h0;
    repeat (2) @(negedge clk);
    chk("R9", {11'd0, fault_n}, 12'h001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule